// File: doc/BRIEF.md
# AFSK Tone Modulator with NRZI and Bit Stuffing

The block turns a byte stream into 1200-baud audio frequency-shift keyed samples for a DAC. Bytes arrive on a valid/ready input and are sent least significant bit first. The line code is NRZI: a data 0 is sent by switching between the mark tone (1200 Hz) and the space tone (2200 Hz), and a data 1 keeps the tone. After five ones in a row the block inserts a zero, which keeps the HDLC flag pattern unique. Frame flag and abort bytes normally go out without stuffing. An escape byte in front of any byte sends that byte as ordinary data with stuffing enabled.

The tone is made by a phase accumulator. On each sample strobe it adds a step chosen by the current tone. The accumulator indexes a 512-point sine wave, which is normally built from a 128-entry quarter table by mirroring. One 8-bit unsigned sample comes out per strobe. A busy flag is high from the first accepted byte until a bit boundary is reached with no byte waiting.

Top module: `afsk_modulator`

## Requirements
- R1: After reset `busy` is 0, `in_ready` is 1 and `dac_sample` is 128, which is the wave value at phase 0.
- R2: On each strobe while busy, the 9-bit phase moves forward modulo 512. The step is 64 on the mark tone and 117 on the space tone. These are round(512·f/9600) for 1200 Hz and 2200 Hz.
- R3: `dac_sample` is the wave value at the current phase p. Let k = p mod 256, and let k' = k if k < 128, else 255 − k. Let v = round(128 + 127·sin(π·k'/256)). The output is v when p < 256 and 255 − v when p ≥ 256.
- R4: Every transmitted bit, inserted zeros included, lasts exactly 8 strobes (9600/1200). The tone changes only on the first strobe of a bit.
- R5: Data bits go out LSB first. A 1 keeps the tone and adds one to the run-of-ones count. A 0 switches the tone and clears the count.
- R6: While stuffing is enabled, a run count of 5 at a bit start makes that bit an inserted zero. The tone switches, the count clears, and the pending data bit waits for the next bit slot.
- R7: The escape byte 0x1B is not sent itself. The byte after it is sent literally with stuffing enabled, even if it is 0x7E, 0x7F or 0x1B.
- R8: An unescaped 0x7E (flag) or 0x7F (abort) is sent with stuffing disabled, so all of its ones go out with no inserted zero.
- R9: When a byte is fetched right after a byte sent with stuffing disabled, the run count is cleared first. After a stuffed byte the count carries over.
- R10: Transmission starts on the mark tone. If no byte is waiting when a byte boundary is reached, that strobe drops `busy` and leaves `dac_sample` unchanged. While idle the output holds.
- R11: Only one byte can wait at a time. `in_ready` stays low while a byte waits to be sent, and that byte is held unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sample_stb | input | 1 | One-cycle pulse per DAC sample period |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| dac_sample | output | 8 | Unsigned audio sample |
| busy | output | 1 | Transmission in progress |

## Verification
The bench uses the default parameters: a 9600 Hz sample rate, which gives 8 strobes per bit and tone steps of 64 and 117, a stuffing limit of 5, and the folded quarter-table wave. With these values a bit lasts only 40 clock cycles, so long random frames fit in the run. The uneven space step of 117 moves the phase through most of the 512 wave points, which exercises all four mirror quadrants. The directed frames cover runs of 0xFF across byte boundaries, bare and escaped flag and abort bytes, a doubled escape, and gaps long enough that the block stops and later restarts from a held phase.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

   typedef enum logic {
      TONE_MARK  = 1'b0,
      TONE_SPACE = 1'b1
   } tone_e;

   // Rounded quarter-wave point k of a quarter of length qlen, range 128..255
   function automatic int quarter_point(input int k, input int qlen);
      real ang;
      ang = 3.141592653589793 * real'(k) / (2.0 * real'(qlen));
      return $rtoi(128.0 + 127.0 * $sin(ang) + 0.5);
   endfunction

   // Full-wave point i of a wave of length wlen, built by mirroring
   function automatic int wave_point(input int i, input int wlen);
      int half;
      int qlen;
      int h;
      int k;
      int v;
      half = wlen / 2;
      qlen = wlen / 4;
      h    = i % half;
      k    = (h >= qlen) ? (half - 1 - h) : h;
      v    = quarter_point(k, qlen);
      return (i >= half) ? (255 - v) : v;
   endfunction

endpackage

// File: rtl/afsk_sine_lut.sv
module afsk_sine_lut #(
   parameter int WAVE_LEN     = 512,
   parameter bit FOLD_QUARTER = 1'b1
) (
   input  logic [$clog2(WAVE_LEN)-1:0] idx,
   output logic [7:0]                  val
);
   localparam int AW      = $clog2(WAVE_LEN);
   localparam int QUARTER = WAVE_LEN / 4;

   generate
      if (WAVE_LEN != (1 << AW) || WAVE_LEN < 8) begin : g_bad_len
         $error("afsk_sine_lut: WAVE_LEN must be a power of two of at least 8");
      end

      if (FOLD_QUARTER) begin : g_fold
         logic [7:0]    qtab [QUARTER];
         logic [AW-2:0] half_idx;
         logic [AW-3:0] q_idx;
         logic [7:0]    qval;

         for (genvar i = 0; i < QUARTER; i++) begin : g_q
            localparam logic [7:0] PT = 8'(afsk_pkg::quarter_point(i, QUARTER));
            assign qtab[i] = PT;
         end

         assign half_idx = idx[AW-2:0];
         // second quarter of each half reads the table backwards
         assign q_idx    = half_idx[AW-2] ? ~half_idx[AW-3:0] : half_idx[AW-3:0];
         assign qval     = qtab[q_idx];
         assign val      = idx[AW-1] ? (8'd255 - qval) : qval;
      end else begin : g_full
         logic [7:0] ftab [WAVE_LEN];

         for (genvar i = 0; i < WAVE_LEN; i++) begin : g_f
            localparam logic [7:0] PT = 8'(afsk_pkg::wave_point(i, WAVE_LEN));
            assign ftab[i] = PT;
         end

         assign val = ftab[idx];
      end
   endgenerate

endmodule

// File: rtl/afsk_dds.sv
module afsk_dds #(
   parameter int WAVE_LEN     = 512,
   parameter int DAC_RATE     = 9600,
   parameter int MARK_HZ      = 1200,
   parameter int SPACE_HZ     = 2200,
   parameter bit FOLD_QUARTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  afsk_pkg::tone_e  tone_sel,
   output logic [7:0]       sample
);
   import afsk_pkg::*;

   localparam int AW         = $clog2(WAVE_LEN);
   localparam int MARK_STEP  = (WAVE_LEN * MARK_HZ + DAC_RATE / 2) / DAC_RATE;
   localparam int SPACE_STEP = (WAVE_LEN * SPACE_HZ + DAC_RATE / 2) / DAC_RATE;
   localparam logic [AW-1:0] MARK_INC  = AW'(MARK_STEP);
   localparam logic [AW-1:0] SPACE_INC = AW'(SPACE_STEP);

   generate
      if (MARK_STEP < 1 || SPACE_STEP >= WAVE_LEN / 2) begin : g_bad_step
         $error("afsk_dds: tone steps fall outside the usable range");
      end
   endgenerate

   logic [AW-1:0] phase_q;
   logic [AW-1:0] step;

   assign step = (tone_sel == TONE_SPACE) ? SPACE_INC : MARK_INC;

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= '0;
      else if (advance) phase_q <= phase_q + step;   // wraps modulo WAVE_LEN
   end

   afsk_sine_lut #(
      .WAVE_LEN     (WAVE_LEN),
      .FOLD_QUARTER (FOLD_QUARTER)
   ) u_lut (
      .idx (phase_q),
      .val (sample)
   );

   AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(phase_q)) else $error("phase moved without a strobe"); // R10

endmodule

// File: rtl/afsk_byte_stage.sv
module afsk_byte_stage #(
   parameter logic [7:0] ESC_BYTE = 8'h1B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic       take,
   output logic       held,
   output logic [7:0] held_data,
   output logic       held_lit
);
   logic esc_pend;
   logic accept;

   assign in_ready = !held;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_data <= '0;
         held_lit  <= 1'b0;
         esc_pend  <= 1'b0;
      end else begin
         if (take) held <= 1'b0;
         if (accept) begin
            if (!esc_pend && in_data == ESC_BYTE) begin
               esc_pend <= 1'b1;                 // absorbed, never transmitted
            end else begin
               held      <= 1'b1;
               held_data <= in_data;
               held_lit  <= esc_pend;
               esc_pend  <= 1'b0;
            end
         end
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      held && !take |=> held && $stable(held_data) && $stable(held_lit)) else $error("waiting byte lost"); // R11
   AST_ESC_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !esc_pend && in_data == ESC_BYTE |=> !held) else $error("escape byte was queued"); // R7

endmodule

// File: rtl/afsk_bit_engine.sv
module afsk_bit_engine #(
   parameter int         SAMPLES_PER_BIT = 8,
   parameter int         STUFF_LIMIT     = 5,
   parameter logic [7:0] FLAG_BYTE       = 8'h7E,
   parameter logic [7:0] ABORT_BYTE      = 8'h7F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sample_stb,
   input  logic            held,
   input  logic [7:0]      held_data,
   input  logic            held_lit,
   output logic            take,
   output logic            busy,
   output logic            advance,
   output afsk_pkg::tone_e tone_next
);
   import afsk_pkg::*;

   localparam int CW = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(SAMPLES_PER_BIT - 1);
   localparam logic [3:0]    RUN_MAX  = 4'(STUFF_LIMIT);

   generate
      if (STUFF_LIMIT < 1 || STUFF_LIMIT > 14) begin : g_bad_limit
         $error("afsk_bit_engine: STUFF_LIMIT out of range");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [7:0]    sh_q, sh_n;
   logic [3:0]    left_q, left_n;
   logic [3:0]    ones_q, ones_n;
   logic          stuff_q, stuff_n;
   tone_e         tone_q, tone_n;
   logic          bit_start;
   logic          starve;
   logic          bit_step;

   assign bit_start = sample_stb && busy && (cnt_q == '0);
   assign starve    = (left_q == '0) && !held;
   assign bit_step  = bit_start && !starve;
   assign take      = bit_step && (left_q == '0);
   assign advance   = sample_stb && busy && !(bit_start && starve);
   assign tone_next = tone_n;

   always_comb begin
      sh_n    = sh_q;
      left_n  = left_q;
      ones_n  = ones_q;
      stuff_n = stuff_q;
      tone_n  = tone_q;
      if (bit_step) begin
         if (left_q == '0) begin
            if (!stuff_q) ones_n = '0;
            sh_n    = held_data;
            left_n  = 4'd8;
            stuff_n = held_lit || !(held_data == FLAG_BYTE || held_data == ABORT_BYTE);
         end
         if (stuff_n && ones_n >= RUN_MAX) begin
            tone_n = (tone_q == TONE_MARK) ? TONE_SPACE : TONE_MARK;   // inserted zero
            ones_n = '0;
         end else begin
            if (sh_n[0]) begin
               if (ones_n != 4'hF) ones_n = ones_n + 4'd1;
            end else begin
               ones_n = '0;
               tone_n = (tone_q == TONE_MARK) ? TONE_SPACE : TONE_MARK;
            end
            sh_n   = {1'b0, sh_n[7:1]};
            left_n = left_n - 4'd1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt_q   <= '0;
         sh_q    <= '0;
         left_q  <= '0;
         ones_q  <= '0;
         stuff_q <= 1'b1;
         tone_q  <= TONE_MARK;
      end else if (!busy) begin
         if (held) begin
            busy   <= 1'b1;
            tone_q <= TONE_MARK;
            cnt_q  <= '0;
            left_q <= '0;
         end
      end else if (sample_stb) begin
         if (cnt_q == '0) begin
            if (starve) begin
               busy <= 1'b0;
            end else begin
               sh_q    <= sh_n;
               left_q  <= left_n;
               ones_q  <= ones_n;
               stuff_q <= stuff_n;
               tone_q  <= tone_n;
               cnt_q   <= CNT_LAST;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy && stuff_q |-> ones_q <= RUN_MAX) else $error("ones run passed the stuffing limit"); // R6
   AST_TONE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bit_start |=> $stable(tone_q)) else $error("tone changed inside a bit"); // R4
   AST_START_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> tone_q == TONE_MARK) else $error("transmission not started on mark"); // R10

endmodule

// File: rtl/afsk_modulator.sv
module afsk_modulator #(
   parameter int         DAC_RATE     = 9600,
   parameter int         BAUD         = 1200,
   parameter int         MARK_HZ      = 1200,
   parameter int         SPACE_HZ     = 2200,
   parameter int         WAVE_LEN     = 512,
   parameter bit         FOLD_QUARTER = 1'b1,
   parameter int         STUFF_LIMIT  = 5,
   parameter logic [7:0] FLAG_BYTE    = 8'h7E,
   parameter logic [7:0] ABORT_BYTE   = 8'h7F,
   parameter logic [7:0] ESC_BYTE     = 8'h1B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_stb,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   output logic [7:0] dac_sample,
   output logic       busy
);
   import afsk_pkg::*;

   localparam int SAMPLES_PER_BIT = DAC_RATE / BAUD;

   generate
      if (DAC_RATE % BAUD != 0 || SAMPLES_PER_BIT < 2) begin : g_bad_rate
         $error("afsk_modulator: DAC_RATE must be a multiple (at least 2x) of BAUD");
      end
   endgenerate

   logic       held;
   logic [7:0] held_data;
   logic       held_lit;
   logic       take;
   logic       advance;
   tone_e      tone_next;

   afsk_byte_stage #(
      .ESC_BYTE (ESC_BYTE)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .take      (take),
      .held      (held),
      .held_data (held_data),
      .held_lit  (held_lit)
   );

   afsk_bit_engine #(
      .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
      .STUFF_LIMIT     (STUFF_LIMIT),
      .FLAG_BYTE       (FLAG_BYTE),
      .ABORT_BYTE      (ABORT_BYTE)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .held       (held),
      .held_data  (held_data),
      .held_lit   (held_lit),
      .take       (take),
      .busy       (busy),
      .advance    (advance),
      .tone_next  (tone_next)
   );

   afsk_dds #(
      .WAVE_LEN     (WAVE_LEN),
      .DAC_RATE     (DAC_RATE),
      .MARK_HZ      (MARK_HZ),
      .SPACE_HZ     (SPACE_HZ),
      .FOLD_QUARTER (FOLD_QUARTER)
   ) u_dds (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .tone_sel (tone_next),
      .sample   (dac_sample)
   );

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(dac_sample)) else $error("output moved while idle"); // R10

endmodule

// File: tb/afsk_modulator_tb.sv
module afsk_modulator_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_stb = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] dac_sample;
   logic       busy;

   int n_cmp  = 0;
   int n_miss = 0;

   afsk_modulator u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .dac_sample (dac_sample),
      .busy       (busy)
   );

   always #4 clk = ~clk;

   // ---------------- expected wave (R3) ----------------
   int wave [512];

   function automatic int calc_wave(input int p);
      int k;
      int v;
      k = p % 256;
      if (k >= 128) k = 255 - k;
      v = $rtoi(128.0 + 127.0 * $sin(3.141592653589793 * real'(k) / 256.0) + 0.5);
      return (p >= 256) ? 255 - v : v;
   endfunction

   // ---------------- reference model ----------------
   logic [7:0] tx_q [$];     // raw bytes still to hand to the port
   logic [8:0] items [$];    // {literal, data} per transmitted byte
   bit  m_escp  = 0;
   bit  m_busy  = 0;
   int  m_acc   = 0;
   bit  m_tone  = 0;          // 0 mark, 1 space
   int  m_cnt   = 0;
   int  m_left  = 0;
   logic [7:0] m_sh = 0;
   bit  m_en    = 1;
   int  m_ones  = 0;

   task automatic push_byte(input logic [7:0] b);
      tx_q.push_back(b);
      if (!m_escp && b == 8'h1B) m_escp = 1;
      else begin
         items.push_back({m_escp, b});
         m_escp = 0;
      end
   endtask

   task automatic push_frame_start();
      if (!m_busy && items.size() != 0) begin
         m_busy = 1; m_tone = 0; m_cnt = 0; m_left = 0;
      end
   endtask

   task automatic model_strobe();
      logic [8:0] it;
      if (!m_busy) return;
      if (m_cnt == 0) begin
         if (m_left == 0 && items.size() == 0) begin
            m_busy = 0;
            return;
         end
         if (m_left == 0) begin
            if (!m_en) m_ones = 0;
            it     = items.pop_front();
            m_sh   = it[7:0];
            m_left = 8;
            m_en   = it[8] || !(it[7:0] == 8'h7E || it[7:0] == 8'h7F);
         end
         if (m_en && m_ones >= 5) begin
            m_tone = !m_tone; m_ones = 0;
         end else begin
            if (m_sh[0]) begin
               if (m_ones < 15) m_ones++;
            end else begin
               m_ones = 0; m_tone = !m_tone;
            end
            m_sh = m_sh >> 1;
            m_left--;
         end
         m_cnt = 7;
      end else m_cnt--;
      m_acc = (m_acc + (m_tone ? 117 : 64)) % 512;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_miss++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- input feeder ----------------
   initial begin
      bit hs;
      hs = 0;
      forever begin
         @(negedge clk);
         if (hs && tx_q.size() != 0) void'(tx_q.pop_front());
         if (!rst_n) begin
            in_valid = 0; hs = 0;
         end else begin
            in_valid = (tx_q.size() != 0);
            in_data  = (tx_q.size() != 0) ? tx_q[0] : 8'h00;
            hs = in_valid && in_ready;
         end
      end
   end

   task automatic strobe(input string tag);
      @(negedge clk);
      sample_stb = 1;
      @(negedge clk);
      sample_stb = 0;
      model_strobe();
      check(busy == m_busy, {tag, " busy"}, int'(busy), int'(m_busy));
      check(int'(dac_sample) == wave[m_acc], {tag, " sample"}, int'(dac_sample), wave[m_acc]);
      repeat (3) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] bytes [$]);
      foreach (bytes[i]) push_byte(bytes[i]);
      repeat (4) @(negedge clk);
      push_frame_start();
   endtask

   task automatic drain(input string tag);
      while (m_busy) strobe(tag);
      repeat (3) strobe({tag, " R10 idle"});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      logic [7:0] fr [$];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 512; i++) wave[i] = calc_wave(i);

      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(busy == 0, "R1 busy", int'(busy), 0);
      check(in_ready == 1, "R1 ready", int'(in_ready), 1);
      check(dac_sample == 8'd128, "R1 sample", int'(dac_sample), 128);

      // R10: strobes while idle change nothing
      repeat (3) strobe("R10 idle");

      // R11: one byte waits, the next is refused
      fr = '{8'hA5, 8'h3C, 8'h0F};
      send(fr);
      check(in_ready == 0, "R11 ready low while byte waits", int'(in_ready), 0);
      drain("R2 R3 R4 R5 R10 R11");

      // R6: long runs of ones, across a byte boundary
      fr = '{8'hFF, 8'hFF, 8'hF8};
      send(fr);
      drain("R6 stuffing");

      // R8: bare flag and abort, no stuffing
      fr = '{8'h7E, 8'h7E, 8'h7F, 8'h7E};
      send(fr);
      drain("R8 flag abort");

      // R7: escaped flag, abort and escape go out as stuffed data
      fr = '{8'h1B, 8'h7E, 8'h1B, 8'h7F, 8'h1B, 8'h1B, 8'hFF};
      send(fr);
      drain("R7 escape");

      // R9: run count cleared after an unstuffed byte, kept after a stuffed one
      fr = '{8'h7F, 8'hFF, 8'hF0, 8'hFF};
      send(fr);
      drain("R9 run clear");

      // R2 R3 R4 R5: random frames, some appended mid-transmission
      for (int f = 0; f < 22; f++) begin
         int len;
         int gap;
         fr = {};
         len = 1 + int'($urandom_range(4, 0));
         for (int b = 0; b < len; b++) begin
            logic [7:0] v;
            case ($urandom_range(7, 0))
               0: v = 8'h7E;
               1: v = 8'h7F;
               2: v = 8'h1B;
               3: v = 8'hFF;
               default: v = 8'($urandom);
            endcase
            fr.push_back(v);
         end
         send(fr);
         gap = 20 + int'($urandom_range(250, 0));
         for (int s = 0; s < gap; s++) strobe("R2 R3 R4 R5 random");
      end
      drain("R2 R3 R4 R5 R10 final");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
   end

endmodule